// File: doc/BRIEF.md
# Dual-Clock 36-bit FIFO with Selectable Read Timing

This block carries 36-bit words from a write clock domain to a read clock domain. The two clocks run freely. They may be unrelated, or they may be the same clock, and a word may be written and another read on the same edge. Each side keeps a binary pointer and passes a reflected-binary (Gray) copy of it to the other side through two flip-flops. Every status flag is computed only from registers in its own domain. A flag therefore rises on the edge that causes it and falls a few cycles later, once the far pointer has crossed over.

The input `fwft_mode` selects the read timing and is held steady outside reset.

- **Standard mode:** `rd_valid` is the inverse of an empty flag. A pop returns the word on `rd_data` after the next read-clock edge.
- **Fall-through mode:** a one-word output register fetches the head word by itself. `rd_valid` then means that the word shown on `rd_data` is ready to take.

Both ports use a valid/ready handshake.

- **Write side:** a word moves when `wr_valid` and `wr_ready` are both high at a write-clock edge. `wr_ready` low is the back-pressure, and `wr_valid` may wait on it.
- **Read side:** a word moves when `rd_valid` and `rd_ready` are both high at a read-clock edge. `rd_ready` may be held high.

Two thresholds drive the almost-full and almost-empty flags. They are preset from `ofs_sel` while reset is held. One encoding of `ofs_sel` instead allows software to load each threshold later, from its own clock domain.

Top module: `dcfifo36`

## Requirements
- R1: Words leave in the order they were accepted, with all 36 bits intact, in both read timings and with asynchronous or shared clocks.
- R2: `wr_ready` is low exactly when the RAM holds DEPTH words. A `wr_valid` offered while `wr_ready` is low stores nothing.
- R3: In standard mode (`fwft_mode`=0), `rd_valid` is high whenever the RAM holds at least one word. A pop (`rd_valid` and `rd_ready` at a read edge) puts the head word on `rd_data` after that edge. `rd_data` then holds until the next pop, and `rd_ready` with `rd_valid` low has no effect.
- R4: In fall-through mode (`fwft_mode`=1), `rd_valid` high means `rd_data` already shows the head word, and that word stays stable until it is popped. The output register adds one word of capacity beyond DEPTH.
- R5: `almost_full` is high when DEPTH minus the number of words in the RAM is at or below the full threshold. In fall-through mode, the word in the output register is not counted in the RAM.
- R6: `almost_empty` is high when the number of stored words is at or below the empty threshold. In fall-through mode, the stored count includes the word in the output register.
- R7: While reset is held, `ofs_sel` presets both thresholds: 2'b00 gives 8, 2'b01 gives 16 and 2'b10 gives 64. 2'b11 presets both to 8 and enables loading. `af_set` then loads `af_value` on a write edge, and `ae_set` loads `ae_value` on a read edge. With any other encoding, the load strobes are ignored.
- R8: After reset, `wr_ready`=1, `rd_valid`=0, `almost_empty`=1 and `almost_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock, may equal wclk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode | input | 1 | 0 standard timing, 1 fall-through timing; static |
| ofs_sel | input | 2 | Threshold preset/load-enable select, sampled during reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Space available (not full / input ready) |
| wr_data | input | 36 | Write word |
| almost_full | output | 1 | Almost-full flag, wclk domain |
| af_set | input | 1 | Load strobe for the full threshold |
| af_value | input | AW+1 | Full threshold value |
| rd_ready | input | 1 | Read request / pop |
| rd_valid | output | 1 | Standard: not empty; fall-through: output ready |
| rd_data | output | 36 | Read word |
| almost_empty | output | 1 | Almost-empty flag, rclk domain |
| ae_set | input | 1 | Load strobe for the empty threshold |
| ae_value | input | AW+1 | Empty threshold value |

## Verification
The assertions assume the following about the inputs:

- `fwft_mode` and `ofs_sel` change only while reset is held.
- Reset stays low for several edges of both clocks.
- Each threshold load comes from its own clock domain.
- A threshold value never exceeds DEPTH.

The stimulus respects these limits in three ways. It changes mode, select and clock sharing only inside a reset window. It pulses each load strobe only on its own clock. It drives every input from the falling edge of its own clock. Flags are compared only after the pointers have had time to cross, and the comparison uses an arithmetic occupancy model of the fill and drain sweep.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned WORD_W = 36;

  typedef enum logic [1:0] {
    OFS_8    = 2'b00,
    OFS_16   = 2'b01,
    OFS_64   = 2'b10,
    OFS_USER = 2'b11
  } ofs_sel_e;

  function automatic int unsigned preset_ofs(input logic [1:0] sel);
    case (ofs_sel_e'(sel))
      OFS_16:  return 16;
      OFS_64:  return 64;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          almost_full,
  input  logic          af_set,
  input  logic [PW-1:0] af_value,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wen
);
  logic [PW-1:0] wbin, wbin_nx, rbin_s, used, af_ofs;
  logic          user_en;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc       = acc ^ rgray_s[i];
      rbin_s[i] = acc;
    end
  end

  assign used        = wbin - rbin_s;
  assign wr_ready    = (used != PW'(DEPTH));
  assign wen         = wr_valid & wr_ready;
  assign wbin_nx     = wbin + PW'(1);
  assign waddr       = wbin[AW-1:0];
  assign almost_full = ((PW'(DEPTH) - used) <= af_ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wen) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_ofs  <= PW'(preset_ofs(ofs_sel));
      user_en <= (ofs_sel == OFS_USER);
    end else if (user_en && af_set) begin
      af_ofs <= af_value;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  assert_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wgray));
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft,
  input  logic [1:0]        ofs_sel,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              almost_empty,
  input  logic              ae_set,
  input  logic [PW-1:0]     ae_value,
  input  logic [PW-1:0]     wgray_s,
  output logic [PW-1:0]     rgray,
  output logic [AW-1:0]     raddr,
  input  logic [WORD_W-1:0] mem_q
);
  logic [PW-1:0] rbin, rbin_nx, wbin_s, used, occ, ae_ofs;
  logic          ram_empty, fetch, ovalid, user_en;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc       = acc ^ wgray_s[i];
      wbin_s[i] = acc;
    end
  end

  assign used      = wbin_s - rbin;
  assign ram_empty = (used == '0);
  assign rbin_nx   = rbin + PW'(1);
  assign raddr     = rbin[AW-1:0];

  generate
    if (1) begin : g_fetch
      always_comb begin
        if (fwft) fetch = !ram_empty && (!ovalid || rd_ready);
        else      fetch = !ram_empty && rd_ready;
      end
    end
  endgenerate

  assign rd_valid     = fwft ? ovalid : !ram_empty;
  assign occ          = used + PW'(fwft & ovalid);
  assign almost_empty = (occ <= ae_ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      ovalid  <= 1'b0;
    end else begin
      if (fetch) begin
        rbin    <= rbin_nx;
        rgray   <= rbin_nx ^ (rbin_nx >> 1);
        rd_data <= mem_q;
      end
      if (!fwft)         ovalid <= 1'b0;
      else if (fetch)    ovalid <= 1'b1;
      else if (rd_ready) ovalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_ofs  <= PW'(preset_ofs(ofs_sel));
      user_en <= (ofs_sel == OFS_USER);
    end else if (user_en && ae_set) begin
      ae_ofs <= ae_value;
    end
  end

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  assert_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  assert_std_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !(rd_valid && rd_ready)) |=> $stable(rd_data));
  assert_fwft_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/dcfifo36.sv
module dcfifo36
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic [1:0]        ofs_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              almost_full,
  input  logic              af_set,
  input  logic [PW-1:0]     af_value,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              almost_empty,
  input  logic              ae_set,
  input  logic [PW-1:0]     ae_value
);
  logic              w_rst_n, r_rst_n, wen;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_q;

  dcfifo_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(w_rst_n));
  dcfifo_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(r_rst_n));

  dcfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(w_rst_n), .d(rgray), .q(rgray_s));
  dcfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(r_rst_n), .d(wgray), .q(wgray_s));

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wr_data;
  end
  assign mem_q = mem[raddr];

  dcfifo_wside #(.DEPTH(DEPTH)) u_wside (
    .clk(wclk), .rst_n(w_rst_n), .ofs_sel(ofs_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .almost_full(almost_full),
    .af_set(af_set), .af_value(af_value), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .wen(wen)
  );

  dcfifo_rside #(.DEPTH(DEPTH)) u_rside (
    .clk(rclk), .rst_n(r_rst_n), .fwft(fwft_mode), .ofs_sel(ofs_sel),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .almost_empty(almost_empty), .ae_set(ae_set), .ae_value(ae_value),
    .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .mem_q(mem_q)
  );

  assert_reset_state_R8: assert property (@(posedge wclk)
    !w_rst_n |-> (wr_ready && !almost_full));
endmodule

// File: tb/dcfifo36_bench.sv
module dcfifo36_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_HALF  = 7;
  localparam int DEPTH      = 128;
  localparam int PW         = $clog2(DEPTH) + 1;

  logic wfree = 1'b0, rfree = 1'b0, coincide = 1'b0;
  logic wclk, rclk;
  always #(CLK_PERIOD / 2) wfree = ~wfree;
  always #(RCLK_HALF) rfree = ~rfree;
  assign wclk = wfree;
  assign rclk = coincide ? wfree : rfree;

  logic rst_n = 1'b0, fwft_mode = 1'b0;
  logic [1:0] ofs_sel = 2'b00;
  logic wr_valid = 1'b0, wr_ready, almost_full, af_set = 1'b0;
  logic [35:0] wr_data = '0, rd_data;
  logic [PW-1:0] af_value = '0, ae_value = '0;
  logic rd_ready = 1'b0, rd_valid, almost_empty, ae_set = 1'b0;

  dcfifo36 #(.DEPTH(DEPTH)) u_dcfifo36 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .ofs_sel(ofs_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .almost_full(almost_full), .af_set(af_set),
    .af_value(af_value), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .almost_empty(almost_empty), .ae_set(ae_set),
    .ae_value(ae_value)
  );

  int checks = 0, fails = 0;
  int af_o, ae_o;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] pat(input int k);
    return {4'(k ^ 5), 32'(k * 32'h9E3779B1)};
  endfunction

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic do_reset(input bit fw, input logic [1:0] sel, input bit co);
    @(negedge wclk);
    rst_n = 1'b0;
    fwft_mode = fw;
    ofs_sel = sel;
    coincide = co;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic write_one(input logic [35:0] d);
    @(negedge wclk);
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic read_one(output logic [35:0] d);
    @(negedge rclk);
    if (fwft_mode) d = rd_data;
    rd_ready = 1'b1;
    @(negedge rclk);
    rd_ready = 1'b0;
    if (!fwft_mode) d = rd_data;
  endtask

  task automatic check_flags(input int n);
    int ram;
    ram = (fwft_mode && n > 0) ? n - 1 : n;
    chk(wr_ready == (ram < DEPTH), "R2 wr_ready", wr_ready, ram < DEPTH);
    chk(almost_full == ((DEPTH - ram) <= af_o), "R5 almost_full", almost_full, (DEPTH - ram) <= af_o);
    chk(almost_empty == (n <= ae_o), "R6 almost_empty", almost_empty, n <= ae_o);
    chk(rd_valid == (n > 0), fwft_mode ? "R4 rd_valid" : "R3 rd_valid", rd_valid, n > 0);
  endtask

  task automatic sweep(input bit fw, input logic [1:0] sel);
    int total, base;
    logic [35:0] d;
    do_reset(fw, sel, 1'b0);
    chk(wr_ready == 1'b1, "R8 wr_ready", wr_ready, 1);
    chk(rd_valid == 1'b0, "R8 rd_valid", rd_valid, 0);
    chk(almost_empty == 1'b1, "R8 almost_empty", almost_empty, 1);
    chk(almost_full == 1'b0, "R8 almost_full", almost_full, 0);
    // R7: load strobes take effect only with the user encoding
    @(negedge wclk); af_set = 1'b1; af_value = PW'(5);
    @(negedge wclk); af_set = 1'b0;
    @(negedge rclk); ae_set = 1'b1; ae_value = PW'(3);
    @(negedge rclk); ae_set = 1'b0;
    af_o = (sel == 2'b11) ? 5 : (sel == 2'b01) ? 16 : (sel == 2'b10) ? 64 : 8;
    ae_o = (sel == 2'b11) ? 3 : (sel == 2'b01) ? 16 : (sel == 2'b10) ? 64 : 8;
    settle();
    check_flags(0);
    total = DEPTH + (fw ? 1 : 0);
    base = int'(fw) * 1000 + int'(sel) * 300;
    for (int n = 1; n <= total; n++) begin
      write_one(pat(base + n - 1));
      settle();
      check_flags(n);
    end
    // R2: write offered while full must be dropped
    write_one(36'hF_DEAD_BEEF);
    settle();
    check_flags(total);
    for (int k = 0; k < total; k++) begin
      read_one(d);
      chk(d == pat(base + k), "R1 order/data", d, pat(base + k));
      settle();
      check_flags(total - 1 - k);
    end
    // R3: read request while empty has no effect
    @(negedge rclk); rd_ready = 1'b1;
    @(negedge rclk); rd_ready = 1'b0;
    settle();
    chk(rd_valid == 1'b0, "R3 empty read ignored", rd_valid, 0);
  endtask

  task automatic stream(input bit fw, input bit co);
    localparam int N = 300;
    do_reset(fw, 2'b00, co);
    fork
      begin : writer
        int i = 0, cyc = 0;
        while (i < N) begin
          bit acc;
          @(negedge wclk);
          acc = 1'b0;
          cyc++;
          if ((cyc % 7) == 3) wr_valid = 1'b0;
          else begin
            wr_valid = 1'b1;
            wr_data = pat(5000 + i);
            acc = wr_ready;
          end
          @(posedge wclk);
          if (acc) i++;
        end
        @(negedge wclk);
        wr_valid = 1'b0;
      end
      begin : reader
        int got = 0, cyc = 0;
        bit pend = 1'b0;
        while (got < N) begin
          bit want;
          @(negedge rclk);
          cyc++;
          rd_ready = 1'b0;
          if (!fw && pend) begin
            chk(rd_data == pat(5000 + got), "R9 stream std R1", rd_data, pat(5000 + got));
            got++;
            pend = 1'b0;
          end
          want = (cyc < 150) ? ((cyc % 4) == 0) : ((cyc % 3) != 1);
          if (rd_valid && want && got < N) begin
            if (fw) begin
              chk(rd_data == pat(5000 + got), "R9 stream fwft R1", rd_data, pat(5000 + got));
              got++;
            end else pend = 1'b1;
            rd_ready = 1'b1;
          end
        end
        @(negedge rclk);
        rd_ready = 1'b0;
      end
    join
    settle();
    chk(rd_valid == 1'b0, "R9 stream drained", rd_valid, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int fw = 0; fw < 2; fw++)
      for (int sel = 0; sel < 4; sel++)
        sweep(fw[0], sel[1:0]);
    for (int fw = 0; fw < 2; fw++)
      for (int co = 0; co < 2; co++)
        stream(fw[0], co[0]);
    report();
  end
endmodule